// File: doc/BRIEF.md
# Data Trace Synchronization Controller

This block sits beside a data trace message generator and decides, for every traced data read or write, whether the message that goes to the trace queue is a plain data message or a data message with synchronization. A synchronized message carries enough context for a trace decoder to restart its reconstruction. It is therefore required whenever the decoder may have lost track. That happens after reset, after trace is switched on, after leaving low-power or debug mode, after a queue overrun, after a dropped message, on request from an external event pin, and periodically after a fixed number of plain messages.

All of these causes feed one sticky pending flag. Cause pulses set the flag. It clears only when a synchronized message actually goes out to the queue. A separate counter forces a synchronized message after `PERIOD` plain messages, and any synchronized message clears that counter. An access to secure memory, or an access whose message loses a same-cycle collision with a higher-priority trace message, emits nothing. Such an access raises a drop indication and leaves the flag set, so the next emitted message is synchronized. The external event input is active low and asynchronous. It is synchronized and edge-detected inside the block.

Top module: `dtsync_ctrl`

## Requirements
- R1: After reset is released, the first emitted data message has `msg_sync`=1 and the one after it has `msg_sync`=0.
- R2: While `trace_en`=0 an access produces `msg_vld`=0 and `msg_drop`=0. The first message after `trace_en` goes from 0 to 1 has `msg_sync`=1.
- R3: A one-cycle pulse on `lpdbg_exit` makes the next emitted message synchronized.
- R4: A one-cycle pulse on `ovr_recover` makes the next emitted message synchronized.
- R5: After a synchronized message, the next `PERIOD` (default 255) emitted messages are plain and the following one is synchronized.
- R6: Every synchronized message, whatever its cause, restarts the periodic count, so a forced sync is followed by a full `PERIOD` plain messages.
- R7: A high-to-low transition on `evt_n` makes the next message synchronized only while `mod_en`, `trace_en` and `evt_ctl_en` are all 1. One transition gives exactly one request, however long the pin stays low. A gated-off transition has no effect.
- R8: An access with `acc_secure`=1 gives `msg_vld`=0 and `msg_drop`=1, and the next emitted message is synchronized.
- R9: An access with `acc_collide`=1 gives `msg_vld`=0 and `msg_drop`=1, and the next emitted message is synchronized.
- R10: A pending synchronization survives idle cycles and dropped accesses. It is cleared only by an emitted synchronized message, so the message after that one is plain.
- R11: Outputs are registered. They reflect the access presented one clock earlier, and all three are 0 in a cycle after no access. `msg_vld` and `msg_drop` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trace_en | input | 1 | Data trace enable level |
| mod_en | input | 1 | Trace module enable level |
| evt_ctl_en | input | 1 | Enable for event-driven synchronization |
| evt_n | input | 1 | Asynchronous active-low event request pin |
| lpdbg_exit | input | 1 | One-cycle pulse on exit from low-power or debug mode |
| ovr_recover | input | 1 | One-cycle pulse when the queue has recovered from an overrun |
| acc_vld | input | 1 | A traced data access occurs this cycle |
| acc_secure | input | 1 | The access targets secure memory |
| acc_collide | input | 1 | A higher-priority trace message claims the queue this cycle |
| msg_vld | output | 1 | A data message is emitted to the queue |
| msg_sync | output | 1 | Emitted message is the synchronized form (valid with `msg_vld`) |
| msg_drop | output | 1 | The access produced no message (secure or collision) |

## Verification
Every result of an access is due on the clock edge after the access is presented. The bench drives an access just after a falling edge and samples the three outputs at the next falling edge, half a period after the registering edge. Cause pulses (`lpdbg_exit`, `ovr_recover`, a rise of `trace_en`) are held for one cycle before the access that should carry the sync. A fall on `evt_n` passes two synchronizer stages and an edge register, so the bench waits four cycles after it before presenting the access. The periodic rule is checked by counting exact message positions between syncs.

// File: rtl/dtsync_pkg.sv
package dtsync_pkg;

  // Kind of data trace message written to the queue.
  typedef enum logic {
    KIND_PLAIN = 1'b0,
    KIND_SYNC  = 1'b1
  } msg_kind_e;

  // Default number of plain messages allowed between two synchronized ones.
  localparam int unsigned DEF_PERIOD = 255;

  // Default depth of the event pin synchronizer.
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/dtsync_evt_sync.sv
module dtsync_evt_sync #(
  parameter int unsigned STAGES = dtsync_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic evt_n,
  output logic evt_fall
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;
  logic          prev_q;
  logic          prev_d;

  // Shift chain: stage 0 captures the pin, later stages re-register.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = evt_n;
      end else begin : g_next
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    prev_d   = sync_q[LAST];
    evt_fall = prev_q & ~sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // One transition yields a single-cycle request (R7).
  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    evt_fall |=> !evt_fall);

endmodule

// File: rtl/dtsync_period_cnt.sv
module dtsync_period_cnt #(
  parameter int unsigned PERIOD = dtsync_pkg::DEF_PERIOD
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic plain_emit,
  input  logic sync_emit,
  output logic hit
);

  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERIOD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = sync_emit | (plain_emit & (cnt_q != LIMIT));
    if (sync_emit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    hit = (cnt_q == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Count never passes the period (R5).
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  // A reached period is never followed by a plain message (R5).
  assert_hit_forces_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |-> !plain_emit);

  // Any sync message restarts the count (R6).
  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    sync_emit |=> (cnt_q == '0));

endmodule

// File: rtl/dtsync_pend.sv
module dtsync_pend (
  input  logic clk,
  input  logic rst_ni,
  input  logic cause,
  input  logic lost,
  input  logic sync_emit,
  output logic force_sync
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    force_sync = pend_q | cause;
    pend_d     = lost | (force_sync & ~sync_emit);
  end

  // Reset value 1: the first message after reset is synchronized (R1).
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
    end
  end

  // A dropped message leaves a pending sync (R8, R9).
  assert_lost_sets_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    lost |=> pend_q);

  // Pending flag persists until a sync message leaves (R10).
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !sync_emit) |=> pend_q);

  // Emitted sync with no new cause clears the flag (R10).
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (sync_emit && !lost) |=> !pend_q);

endmodule

// File: rtl/dtsync_ctrl.sv
module dtsync_ctrl #(
  parameter int unsigned PERIOD      = dtsync_pkg::DEF_PERIOD,
  parameter int unsigned SYNC_STAGES = dtsync_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_en,
  input  logic mod_en,
  input  logic evt_ctl_en,
  input  logic evt_n,
  input  logic lpdbg_exit,
  input  logic ovr_recover,
  input  logic acc_vld,
  input  logic acc_secure,
  input  logic acc_collide,
  output logic msg_vld,
  output logic msg_sync,
  output logic msg_drop
);

  import dtsync_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_sync_q[1];

  // Enable edge tracking.
  logic trace_q;
  logic trace_d;
  logic trace_rise;

  // Sub-block interconnect.
  logic      evt_fall;
  logic      evt_req;
  logic      cause;
  logic      force_sync;
  logic      period_hit;
  logic      acc_live;
  logic      emit;
  logic      lost;
  logic      sync_now;
  logic      sync_emit;
  logic      plain_emit;
  msg_kind_e kind;

  // Registered outputs.
  logic vld_q, vld_d;
  logic sync_q, sync_d;
  logic drop_q, drop_d;

  dtsync_evt_sync #(
    .STAGES (SYNC_STAGES)
  ) u_evt (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .evt_n    (evt_n),
    .evt_fall (evt_fall)
  );

  dtsync_pend u_pend (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .cause      (cause),
    .lost       (lost),
    .sync_emit  (sync_emit),
    .force_sync (force_sync)
  );

  dtsync_period_cnt #(
    .PERIOD (PERIOD)
  ) u_cnt (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .plain_emit (plain_emit),
    .sync_emit  (sync_emit),
    .hit        (period_hit)
  );

  always_comb begin
    trace_d    = trace_en;
    trace_rise = trace_en & ~trace_q;
    evt_req    = evt_fall & mod_en & trace_en & evt_ctl_en;
    cause      = trace_rise | lpdbg_exit | ovr_recover | evt_req;

    acc_live   = acc_vld & trace_en;
    lost       = acc_live & (acc_secure | acc_collide);
    emit       = acc_live & ~acc_secure & ~acc_collide;

    sync_now   = force_sync | period_hit;
    kind       = sync_now ? KIND_SYNC : KIND_PLAIN;
    sync_emit  = emit & (kind == KIND_SYNC);
    plain_emit = emit & (kind == KIND_PLAIN);

    vld_d      = emit;
    sync_d     = sync_emit;
    drop_d     = lost;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      trace_q <= 1'b0;
      vld_q   <= 1'b0;
      sync_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      trace_q <= trace_d;
      vld_q   <= vld_d;
      sync_q  <= sync_d;
      drop_q  <= drop_d;
    end
  end

  assign msg_vld  = vld_q;
  assign msg_sync = sync_q;
  assign msg_drop = drop_q;

  // Emission and drop are exclusive (R11).
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !(msg_vld && msg_drop));

  // Sync kind only accompanies an emitted message (R11).
  assert_sync_valid_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    msg_sync |-> msg_vld);

  // Without trace enabled nothing leaves the block (R2).
  assert_quiet_off_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !trace_en |=> (!msg_vld && !msg_drop));

  // A secure access never yields a message (R8).
  assert_secure_drop_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_vld && trace_en && acc_secure) |=> (msg_drop && !msg_vld));

endmodule

// File: tb/dtsync_ctrl_test.sv
module dtsync_ctrl_test;

  localparam int unsigned PERIOD = 255;

  logic clk = 1'b0;
  logic rst_n;
  logic trace_en, mod_en, evt_ctl_en, evt_n;
  logic lpdbg_exit, ovr_recover;
  logic acc_vld, acc_secure, acc_collide;
  logic msg_vld, msg_sync, msg_drop;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dtsync_ctrl #(.PERIOD(PERIOD)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .trace_en    (trace_en),
    .mod_en      (mod_en),
    .evt_ctl_en  (evt_ctl_en),
    .evt_n       (evt_n),
    .lpdbg_exit  (lpdbg_exit),
    .ovr_recover (ovr_recover),
    .acc_vld     (acc_vld),
    .acc_secure  (acc_secure),
    .acc_collide (acc_collide),
    .msg_vld     (msg_vld),
    .msg_sync    (msg_sync),
    .msg_drop    (msg_drop)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check3(input string req, input logic v, input logic s, input logic d);
    checks = checks + 1;
    if (msg_vld !== v || msg_sync !== s || msg_drop !== d) begin
      errors = errors + 1;
      $display("FAIL %s: actual vld/sync/drop=%b%b%b expected=%b%b%b",
               req, msg_vld, msg_sync, msg_drop, v, s, d);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Present one access, sample its registered result one cycle later.
  task automatic access(input logic sec, input logic col, input string req,
                        input logic v, input logic s, input logic d);
    acc_vld = 1'b1; acc_secure = sec; acc_collide = col;
    @(negedge clk);
    acc_vld = 1'b0; acc_secure = 1'b0; acc_collide = 1'b0;
    check3(req, v, s, d);
  endtask

  task automatic pulse_lp();
    lpdbg_exit = 1'b1; @(negedge clk); lpdbg_exit = 1'b0;
  endtask

  task automatic t_reset();
    check3("R11 reset quiet", 1'b0, 1'b0, 1'b0);
    access(0, 0, "R1 first sync", 1, 1, 0);
    access(0, 0, "R1 then plain", 1, 0, 0);
    idle(1);
    check3("R11 idle quiet", 0, 0, 0);
  endtask

  task automatic t_enable();
    trace_en = 1'b0; idle(2);
    access(0, 0, "R2 disabled silent", 0, 0, 0);
    access(1, 0, "R2 disabled secure silent", 0, 0, 0);
    trace_en = 1'b1; idle(1);
    access(0, 0, "R2 sync after enable", 1, 1, 0);
    access(0, 0, "R10 plain after sync", 1, 0, 0);
  endtask

  task automatic t_lp();
    pulse_lp();
    access(0, 0, "R3 sync after lp exit", 1, 1, 0);
    access(0, 0, "R3 plain after", 1, 0, 0);
  endtask

  task automatic t_ovr();
    ovr_recover = 1'b1; @(negedge clk); ovr_recover = 1'b0;
    access(0, 0, "R4 sync after overrun", 1, 1, 0);
    access(0, 0, "R4 plain after", 1, 0, 0);
  endtask

  task automatic t_secure();
    access(1, 0, "R8 secure dropped", 0, 0, 1);
    idle(3);
    access(0, 1, "R10 drop keeps pending", 0, 0, 1);
    access(0, 0, "R8 sync after secure", 1, 1, 0);
    access(0, 0, "R10 plain after", 1, 0, 0);
  endtask

  task automatic t_collide();
    access(0, 1, "R9 collision dropped", 0, 0, 1);
    access(0, 0, "R9 sync after collision", 1, 1, 0);
    access(0, 0, "R9 plain after", 1, 0, 0);
  endtask

  task automatic t_event();
    evt_ctl_en = 1'b0;
    evt_n = 1'b0; idle(4);
    access(0, 0, "R7 gated event ignored", 1, 0, 0);
    evt_n = 1'b1; idle(4);
    evt_ctl_en = 1'b1;
    evt_n = 1'b0; idle(4);
    access(0, 0, "R7 event sync", 1, 1, 0);
    idle(4);
    access(0, 0, "R7 held low no repeat", 1, 0, 0);
    evt_n = 1'b1; idle(4);
    mod_en = 1'b0;
    evt_n = 1'b0; idle(4);
    access(0, 0, "R7 module off ignored", 1, 0, 0);
    evt_n = 1'b1; mod_en = 1'b1; idle(4);
  endtask

  task automatic t_period();
    int bad;
    pulse_lp();
    access(0, 0, "R5 seed sync", 1, 1, 0);
    bad = 0;
    for (int i = 0; i < PERIOD; i++) begin
      acc_vld = 1'b1; @(negedge clk); acc_vld = 1'b0;
      if (msg_vld !== 1'b1 || msg_sync !== 1'b0) bad = bad + 1;
    end
    checks = checks + 1;
    if (bad != 0) begin
      errors = errors + 1;
      $display("FAIL R5 plain run: actual bad=%0d expected=0", bad);
    end
    access(0, 0, "R5 periodic sync", 1, 1, 0);
    access(0, 0, "R5 plain after periodic", 1, 0, 0);
  endtask

  task automatic t_restart();
    int bad;
    pulse_lp();
    access(0, 0, "R6 seed sync", 1, 1, 0);
    for (int i = 0; i < 100; i++) begin
      acc_vld = 1'b1; @(negedge clk); acc_vld = 1'b0;
    end
    pulse_lp();
    access(0, 0, "R6 forced sync", 1, 1, 0);
    bad = 0;
    for (int i = 0; i < PERIOD; i++) begin
      acc_vld = 1'b1; @(negedge clk); acc_vld = 1'b0;
      if (msg_vld !== 1'b1 || msg_sync !== 1'b0) bad = bad + 1;
    end
    checks = checks + 1;
    if (bad != 0) begin
      errors = errors + 1;
      $display("FAIL R6 full run after forced sync: actual bad=%0d expected=0", bad);
    end
    access(0, 0, "R6 periodic after restart", 1, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; trace_en = 1'b1; mod_en = 1'b1; evt_ctl_en = 1'b1;
    evt_n = 1'b1; lpdbg_exit = 1'b0; ovr_recover = 1'b0;
    acc_vld = 1'b0; acc_secure = 1'b0; acc_collide = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_enable();
    t_lp();
    t_ovr();
    t_secure();
    t_collide();
    t_event();
    t_period();
    t_restart();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule